// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block sits next to a processor core and decides, on every clock, whether an interrupt should be requested and which one. It combines a vector of external interrupt level lines with the software interrupt register into one pending-level vector. Two timer-match bits in the software register do not have level positions of their own: either one raises level 14. The block then selects the highest pending level that is strictly above the core's current processor interrupt level (PIL). It presents that level to the core as a registered request together with a 9-bit trap-type code.

The core supplies its global interrupt-enable bit, its trap nesting depth and the trap type it is handling at present. While a trap is nested (depth above zero) and the trap being handled has a higher type than the candidate, the block holds its previous output. If any external line rises, the block also emits a one-cycle wake pulse so that a halted core resumes before arbitration. A line that falls only causes the outputs to be re-evaluated.

Top module: `pil_arbiter`

## Requirements
- R1: The pending vector is built as follows. Bit 0 is external line 0. Bits 1..15 are the external lines ORed with software bits 1..15. Software bit 0 (tick match) and software bit 16 (system-tick match) never appear at their own positions.
- R2: If software bit 0 or software bit 16 is set, pending level 14 is set.
- R3: If the pending vector, read as an unsigned number, is below 2 shifted left by PIL, the clock edge clears both the request and the trap-type output to zero.
- R4: Otherwise, with interrupts enabled, the highest set pending level in the range PIL+1..15 is selected.
- R5: The trap-type code for level n is 0x40 OR n (9 bits).
- R6: When the trap depth is nonzero and the current trap type is strictly greater than the candidate code, request and trap type keep their previous values. When the depth is zero, the current trap type has no effect.
- R7: The outputs are loaded (request set to 1, trap type set to the new code) only when the new code differs from the stored code. Otherwise both outputs keep their values.
- R8: With the global interrupt enable at 0, the next edge clears the request and the trap type to zero.
- R9: A 0-to-1 transition on any external line yields a wake pulse of exactly one cycle, registered on the edge that first samples the new value. A 1-to-0 transition yields no pulse.
- R10: Level 0 is never requested. With PIL 0 and only line 0 pending, both outputs are cleared.
- R11: Synchronous active-high reset clears the request, the trap type and the wake output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_lvl | input | 16 | External interrupt level lines, bit n = level n |
| soft_int | input | 17 | Software interrupt register; bits 0 and 16 are timer matches |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_depth | input | 3 | Current trap nesting depth |
| cur_tt | input | 9 | Trap type currently being handled |
| irq_req | output | 1 | Interrupt request to the core |
| irq_tt | output | 9 | Trap-type code of the requested level |
| wake | output | 1 | One-cycle pulse that clears the halted state |

## Verification
Every result comes one clock edge after its stimulus. The request, the trap type and the wake pulse are all registered on the first rising edge that samples new inputs. Each bench task drives inputs on a falling edge and reads outputs on the next falling edge, half a period after the register updates. The wake pulse is read again one cycle later to confirm it has dropped. The hold cases (R6, R7) carry state from one step to the next, so each is checked against the value the step before left behind.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int unsigned LEVELS_D = 16;
  localparam int unsigned TT_W_D   = 9;
  localparam int unsigned DEPTH_W_D = 3;
  localparam logic [TT_W_D-1:0] TT_BASE_D = 9'h040;
  localparam int unsigned TIMER_LVL_D = 14;

  function automatic logic [TT_W_D-1:0] tt_code(input logic [TT_W_D-1:0] base,
                                                 input int unsigned lvl);
    return base | TT_W_D'(lvl);
  endfunction
endpackage

// File: rtl/pil_pending_merge.sv
module pil_pending_merge #(
  parameter int unsigned LEVELS    = 16,
  parameter int unsigned TIMER_LVL = 14,
  localparam int unsigned SOFT_W   = LEVELS + 1
) (
  input  logic [LEVELS-1:0] ext_lvl,
  input  logic [SOFT_W-1:0] soft_int,
  output logic [LEVELS-1:0] pending
);
  logic timer_hit;
  assign timer_hit = soft_int[0] | soft_int[SOFT_W-1];

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      if (g == 0) begin : g_zero
        assign pending[g] = ext_lvl[g];
      end else if (g == TIMER_LVL) begin : g_timer
        assign pending[g] = ext_lvl[g] | soft_int[g] | timer_hit;
      end else begin : g_plain
        assign pending[g] = ext_lvl[g] | soft_int[g];
      end
    end
  endgenerate
endmodule

// File: rtl/pil_priority_pick.sv
module pil_priority_pick #(
  parameter int unsigned LEVELS = 16,
  localparam int unsigned PIL_W = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] pending,
  input  logic [PIL_W-1:0]  cur_pil,
  output logic              below,
  output logic              found,
  output logic [PIL_W-1:0]  win_lvl
);
  logic [LEVELS:0]   thresh;
  logic [LEVELS-1:0] cand;

  assign thresh = (LEVELS+1)'(2) << cur_pil;
  assign below  = {1'b0, pending} < thresh;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_cand
      assign cand[g] = pending[g] && ((PIL_W+1)'(g) > {1'b0, cur_pil});
    end
  endgenerate

  always_comb begin
    found   = 1'b0;
    win_lvl = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (cand[k]) begin
        found   = 1'b1;
        win_lvl = PIL_W'(k);
      end
    end
  end
endmodule

// File: rtl/pil_req_ctrl.sv
module pil_req_ctrl
  import pil_pkg::*;
#(
  parameter int unsigned LEVELS  = 16,
  parameter int unsigned TT_W    = 9,
  parameter int unsigned DEPTH_W = 3,
  parameter logic [TT_W-1:0] TT_BASE = 9'h040,
  localparam int unsigned PIL_W  = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               below,
  input  logic               found,
  input  logic [PIL_W-1:0]   win_lvl,
  input  logic               int_en,
  input  logic [DEPTH_W-1:0] trap_depth,
  input  logic [TT_W-1:0]    cur_tt,
  output logic               irq_req,
  output logic [TT_W-1:0]    irq_tt
);
  logic [TT_W-1:0] new_tt;
  logic            blocked;

  assign new_tt  = TT_BASE | TT_W'(win_lvl);
  assign blocked = (trap_depth != '0) && (cur_tt > new_tt);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (below || !int_en) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (found && !blocked && (new_tt != irq_tt)) begin
      irq_req <= 1'b1;
      irq_tt  <= new_tt;
    end
  end
endmodule

// File: rtl/pil_edge_wake.sv
module pil_edge_wake #(
  parameter int unsigned LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] ext_lvl,
  output logic              wake
);
  logic [LEVELS-1:0] ext_prev;

  always_ff @(posedge clk) begin
    ext_prev <= ext_lvl;
    if (rst) wake <= 1'b0;
    else     wake <= |(ext_lvl & ~ext_prev);
  end
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter
  import pil_pkg::*;
#(
  parameter int unsigned LEVELS    = LEVELS_D,
  parameter int unsigned TT_W      = TT_W_D,
  parameter int unsigned DEPTH_W   = DEPTH_W_D,
  parameter int unsigned TIMER_LVL = TIMER_LVL_D,
  parameter logic [TT_W-1:0] TT_BASE = TT_BASE_D,
  localparam int unsigned PIL_W    = $clog2(LEVELS),
  localparam int unsigned SOFT_W   = LEVELS + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVELS-1:0]  ext_lvl,
  input  logic [SOFT_W-1:0]  soft_int,
  input  logic [PIL_W-1:0]   cur_pil,
  input  logic               int_en,
  input  logic [DEPTH_W-1:0] trap_depth,
  input  logic [TT_W-1:0]    cur_tt,
  output logic               irq_req,
  output logic [TT_W-1:0]    irq_tt,
  output logic               wake
);
  logic [LEVELS-1:0] pending;
  logic              below, found;
  logic [PIL_W-1:0]  win_lvl;

  pil_pending_merge #(.LEVELS(LEVELS), .TIMER_LVL(TIMER_LVL)) u_merge (
    .ext_lvl(ext_lvl), .soft_int(soft_int), .pending(pending)
  );

  pil_priority_pick #(.LEVELS(LEVELS)) u_pick (
    .pending(pending), .cur_pil(cur_pil),
    .below(below), .found(found), .win_lvl(win_lvl)
  );

  pil_req_ctrl #(.LEVELS(LEVELS), .TT_W(TT_W), .DEPTH_W(DEPTH_W), .TT_BASE(TT_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .below(below), .found(found), .win_lvl(win_lvl),
    .int_en(int_en), .trap_depth(trap_depth), .cur_tt(cur_tt),
    .irq_req(irq_req), .irq_tt(irq_tt)
  );

  pil_edge_wake #(.LEVELS(LEVELS)) u_wake (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .wake(wake)
  );
endmodule

// File: rtl/pil_arbiter_chk.sv
module pil_arbiter_chk #(
  parameter int unsigned LEVELS  = 16,
  parameter int unsigned TT_W    = 9,
  parameter int unsigned DEPTH_W = 3,
  parameter logic [TT_W-1:0] TT_BASE = 9'h040,
  localparam int unsigned PIL_W  = $clog2(LEVELS),
  localparam int unsigned SOFT_W = LEVELS + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [LEVELS-1:0]  ext_lvl,
  input logic [SOFT_W-1:0]  soft_int,
  input logic [PIL_W-1:0]   cur_pil,
  input logic               int_en,
  input logic [DEPTH_W-1:0] trap_depth,
  input logic [TT_W-1:0]    irq_tt,
  input logic               irq_req,
  input logic               wake
);
  // R5
  req_code_form_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((irq_tt >> PIL_W) == (TT_BASE >> PIL_W)) && (irq_tt[PIL_W-1:0] != '0));

  // R7
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_tt == '0));

  // R8
  disabled_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq_req);

  // R3
  nothing_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ((ext_lvl == '0) && (soft_int == '0)) |=> (!irq_req && irq_tt == '0));

  // R4
  top_level_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (int_en && trap_depth == '0 && ext_lvl[LEVELS-1] && cur_pil != PIL_W'(LEVELS-1))
      |=> (irq_req && irq_tt == (TT_BASE | TT_W'(LEVELS-1))));

  // R9
  rise_wakes_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ext_lvl & ~$past(ext_lvl))) |=> wake);

  // R9
  no_rise_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(ext_lvl & ~$past(ext_lvl))) |=> !wake);
endmodule

bind pil_arbiter pil_arbiter_chk #(
  .LEVELS(LEVELS), .TT_W(TT_W), .DEPTH_W(DEPTH_W), .TT_BASE(TT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int), .cur_pil(cur_pil),
  .int_en(int_en), .trap_depth(trap_depth), .irq_tt(irq_tt), .irq_req(irq_req),
  .wake(wake)
);

// File: tb/pil_arbiter_test.sv
`timescale 1ns/1ps
module pil_arbiter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_lvl = '0;
  logic [16:0] soft_int = '0;
  logic [3:0]  cur_pil = '0;
  logic        int_en = 1'b1;
  logic [2:0]  trap_depth = '0;
  logic [8:0]  cur_tt = '0;
  logic        irq_req;
  logic [8:0]  irq_tt;
  logic        wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pil_arbiter uut (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int), .cur_pil(cur_pil),
    .int_en(int_en), .trap_depth(trap_depth), .cur_tt(cur_tt),
    .irq_req(irq_req), .irq_tt(irq_tt), .wake(wake)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, result registered on the next rising edge,
  // sampled on the falling edge after it
  task automatic step(input logic [15:0] e, input logic [16:0] s, input logic [3:0] p,
                      input logic en, input logic [2:0] d, input logic [8:0] t);
    ext_lvl = e; soft_int = s; cur_pil = p; int_en = en; trap_depth = d; cur_tt = t;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic r, input logic [8:0] t);
    chk(req, "irq_req", int'(irq_req), int'(r));
    chk(req, "irq_tt", int'(irq_tt), int'(t));
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_out("R11", 1'b0, 9'h000);
    chk("R11", "wake", int'(wake), 0);
    rst = 1'b0;
  endtask

  task automatic t_pick_and_wake;
    step(16'h0020, 17'h0, 4'd2, 1'b1, 3'd0, 9'h0);
    expect_out("R4", 1'b1, 9'h045);
    chk("R9", "wake on rise", int'(wake), 1);
    step(16'h0020, 17'h0, 4'd2, 1'b1, 3'd0, 9'h0);
    expect_out("R7", 1'b1, 9'h045);
    chk("R9", "wake one cycle", int'(wake), 0);
    step(16'h8020, 17'h0, 4'd2, 1'b1, 3'd0, 9'h0);
    expect_out("R5", 1'b1, 9'h04F);
  endtask

  task automatic t_soft_merge;
    step(16'h0020, 17'h00200, 4'd2, 1'b1, 3'd0, 9'h0);
    expect_out("R1", 1'b1, 9'h049);
    chk("R9", "fall no wake", int'(wake), 0);
    step(16'h0000, 17'h00000, 4'd3, 1'b1, 3'd0, 9'h0);
    expect_out("R3", 1'b0, 9'h000);
    step(16'h0000, 17'h10000, 4'd3, 1'b1, 3'd0, 9'h0);
    expect_out("R2", 1'b1, 9'h04E);
    step(16'h0000, 17'h00000, 4'd0, 1'b1, 3'd0, 9'h0);
    step(16'h0000, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0);
    expect_out("R2", 1'b1, 9'h04E);
    step(16'h0000, 17'h00001, 4'd14, 1'b1, 3'd0, 9'h0);
    expect_out("R1", 1'b0, 9'h000);
  endtask

  task automatic t_threshold;
    step(16'h0010, 17'h0, 4'd4, 1'b1, 3'd0, 9'h0);
    expect_out("R3", 1'b0, 9'h000);
    step(16'h0010, 17'h0, 4'd3, 1'b1, 3'd0, 9'h0);
    expect_out("R3", 1'b1, 9'h044);
    step(16'hFFFF, 17'h1FFFF, 4'd15, 1'b1, 3'd0, 9'h0);
    expect_out("R3", 1'b0, 9'h000);
  endtask

  task automatic t_nested_trap;
    step(16'h0010, 17'h0, 4'd3, 1'b1, 3'd0, 9'h0);
    expect_out("R4", 1'b1, 9'h044);
    step(16'h0100, 17'h0, 4'd3, 1'b1, 3'd1, 9'h050);
    expect_out("R6", 1'b1, 9'h044);
    step(16'h0100, 17'h0, 4'd3, 1'b1, 3'd1, 9'h048);
    expect_out("R6", 1'b1, 9'h048);
    step(16'h0200, 17'h0, 4'd3, 1'b1, 3'd0, 9'h07F);
    expect_out("R6", 1'b1, 9'h049);
  endtask

  task automatic t_disable;
    step(16'h0200, 17'h0, 4'd3, 1'b0, 3'd0, 9'h0);
    expect_out("R8", 1'b0, 9'h000);
    step(16'h0200, 17'h0, 4'd3, 1'b1, 3'd0, 9'h0);
    expect_out("R8", 1'b1, 9'h049);
  endtask

  task automatic t_level_zero;
    step(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0);
    chk("R9", "fall no wake", int'(wake), 0);
    step(16'h0001, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0);
    expect_out("R10", 1'b0, 9'h000);
    chk("R9", "wake on line 0 rise", int'(wake), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        t_reset();
        t_pick_and_wake();
        t_soft_merge();
        t_threshold();
        t_nested_trap();
        t_disable();
        t_level_zero();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule